// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch at a given fetch address will be taken. It holds two direction predictors that work differently. The first is shared by all branches: an 8-bit record of the most recent resolved outcomes selects one of 256 two-bit counters. The second is specific to each branch: the low four address bits select one of 16 four-bit outcome records, and that record selects one of 16 two-bit counters. A third table of 16 two-bit confidence counters, also selected by the low four address bits, decides which of the two answers reaches the output.

Prediction is combinational from `fetch_pc`. Both component answers are brought out next to the final answer, so the fetch pipeline can carry them to resolution. When the branch resolves, the pipeline presents the address, the real outcome and the two component answers it carried on the update port. On that clock edge both component tables and the selected per-branch record are trained. The shared record is shifted too. The confidence counter moves only when the two components had disagreed.

Every two-bit counter is a four-state machine with the states `STRONG_NOT` (0), `WEAK_NOT` (1), `WEAK_TAKEN` (2) and `STRONG_TAKEN` (3). It has two transitions. *Up*, on a taken outcome, moves one state toward `STRONG_TAKEN` and holds in `STRONG_TAKEN`. *Down*, on a not-taken outcome, moves one state toward `STRONG_NOT` and holds in `STRONG_NOT`. A counter in `WEAK_TAKEN` or `STRONG_TAKEN` means "taken". In the confidence table, *up* means "the shared predictor was right".

Top module: `tourn_pred`

## Requirements
- R1: After reset every outcome record is zero, every component counter is `WEAK_NOT` and every confidence counter is `WEAK_NOT`, so `pred_taken`, `pred_gbl` and `pred_loc` are 0 for every address.
- R2: Each counter follows the *up* transition on a taken outcome and the *down* transition on a not-taken outcome, saturating at `STRONG_TAKEN` (3) and `STRONG_NOT` (0) without wrapping.
- R3: The shared record is 8 bits wide and directly indexes the 256-entry shared table. Each accepted update shifts it left by one and places the outcome in bit 0 (1 = taken).
- R4: The per-branch record is chosen by address bits [3:0]. It is 4 bits wide and indexes a 16-entry table. On update, the record chosen by `upd_pc[3:0]` shifts left and takes the outcome in bit 0. Address bits above [3:0] have no effect.
- R5: A confidence counter of 2 or 3 (selected by `fetch_pc[3:0]`) outputs `pred_gbl` as `pred_taken`; 0 or 1 outputs `pred_loc`.
- R6: The confidence counter at `upd_pc[3:0]` is trained only when `upd_gbl_pred` differs from `upd_loc_pred`. It takes *up* when the shared answer matched `upd_taken`, otherwise *down*.
- R7: On every accepted update, the shared counter at the current shared record and the per-branch counter at the chosen record are both trained with the outcome, whichever component was selected.
- R8: A prediction in the same cycle as an update reflects the state before that update. The trained state is visible from the cycle after the edge.
- R9: `pred_gbl` and `pred_loc` always show the two component answers for `fetch_pc`, whether or not they were selected.
- R10: While `upd_valid` is 0, no record or counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Final direction prediction (1 = taken) |
| pred_gbl | output | 1 | Shared-history component answer |
| pred_loc | output | 1 | Per-branch component answer |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| upd_gbl_pred | input | 1 | Shared component answer carried from prediction |
| upd_loc_pred | input | 1 | Per-branch component answer carried from prediction |

## Verification
A prediction and the training of the same entries can fall in one cycle, when `fetch_pc` and `upd_pc` name the same branch while `upd_valid` is high. The bench provokes this on every step: it holds the fetch address equal to the update address across the training edge. It compares the outputs just before that edge with a reference model's pre-update state, and the outputs just after it with the post-update state. Idle cycles that carry misleading update data with `upd_valid` low are judged the same way against an unchanged model.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    typedef enum logic [1:0] {
        STRONG_NOT   = 2'd0,
        WEAK_NOT     = 2'd1,
        WEAK_TAKEN   = 2'd2,
        STRONG_TAKEN = 2'd3
    } ctr_t;

    // Saturating up/down transition of a two-bit confidence state machine.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        nxt = cur;
        unique case (cur)
            STRONG_NOT:   nxt = up ? WEAK_NOT     : STRONG_NOT;
            WEAK_NOT:     nxt = up ? WEAK_TAKEN   : STRONG_NOT;
            WEAK_TAKEN:   nxt = up ? STRONG_TAKEN : WEAK_NOT;
            STRONG_TAKEN: nxt = up ? STRONG_TAKEN : WEAK_TAKEN;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_taken(input ctr_t cur);
        return (cur == WEAK_TAKEN) || (cur == STRONG_TAKEN);
    endfunction

endpackage

// File: rtl/ctr_table.sv
module ctr_table
    import tourn_pkg::*;
#(
    parameter int   DEPTH = 16,
    parameter ctr_t INIT  = WEAK_NOT,
    localparam int  IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    ctr_t mem [DEPTH];
    ctr_t cur_w;
    ctr_t nxt_w;

    always_comb begin
        cur_w  = mem[wr_idx];
        nxt_w  = ctr_step(cur_w, wr_up);
        rd_ctr = mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= nxt_w;
        end
    end

    // R2: top state holds under up, bottom state holds under down
    a_r2_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && cur_w == STRONG_TAKEN) |-> nxt_w == STRONG_TAKEN);
    a_r2_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && cur_w == STRONG_NOT) |-> nxt_w == STRONG_NOT);
    // R2: away from the saturating ends every write changes the state
    a_r2_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_up && cur_w == STRONG_TAKEN) && !(!wr_up && cur_w == STRONG_NOT))
        |-> nxt_w != cur_w);

endmodule

// File: rtl/local_hist.sv
module local_hist #(
    parameter int  ENTRIES = 16,
    parameter int  HIST_W  = 4,
    localparam int SEL_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] wr_hist
);

    logic [ENTRIES-1:0][HIST_W-1:0] hist;

    always_comb begin
        rd_hist = hist[rd_sel];
        wr_hist = hist[wr_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (wr_en) begin
            hist[wr_sel] <= {wr_hist[HIST_W-2:0], wr_bit};
        end
    end

    // R10: no write request, no record changes
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hist));
    // R4: newest outcome lands in bit 0 of the selected record
    a_r4_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist[$past(wr_sel)][0] == $past(wr_bit));

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
    import tourn_pkg::*;
#(
    parameter int  PC_W    = 32,
    parameter int  GHIST_W = 8,
    parameter int  SEL_W   = 4,
    parameter int  LHIST_W = 4,
    localparam int G_DEPTH = 1 << GHIST_W,
    localparam int L_DEPTH = 1 << LHIST_W,
    localparam int C_DEPTH = 1 << SEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_gbl,
    output logic            pred_loc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_gbl_pred,
    input  logic            upd_loc_pred
);

    logic [GHIST_W-1:0] ghist;
    logic [LHIST_W-1:0] lh_rd;
    logic [LHIST_W-1:0] lh_wr;
    ctr_t               g_ctr;
    ctr_t               l_ctr;
    ctr_t               c_ctr;
    logic               cho_we;
    logic               cho_up;
    logic               unused_hi;

    assign unused_hi = ^{fetch_pc[PC_W-1:SEL_W], upd_pc[PC_W-1:SEL_W]};

    // shared outcome record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghist <= '0;
        end else if (upd_valid) begin
            ghist <= {ghist[GHIST_W-2:0], upd_taken};
        end
    end

    ctr_table #(.DEPTH(G_DEPTH), .INIT(WEAK_NOT)) u_gtab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist),
        .rd_ctr (g_ctr),
        .wr_en  (upd_valid),
        .wr_idx (ghist),
        .wr_up  (upd_taken)
    );

    local_hist #(.ENTRIES(C_DEPTH), .HIST_W(LHIST_W)) u_lhist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (fetch_pc[SEL_W-1:0]),
        .rd_hist (lh_rd),
        .wr_en   (upd_valid),
        .wr_sel  (upd_pc[SEL_W-1:0]),
        .wr_bit  (upd_taken),
        .wr_hist (lh_wr)
    );

    ctr_table #(.DEPTH(L_DEPTH), .INIT(WEAK_NOT)) u_ltab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lh_rd),
        .rd_ctr (l_ctr),
        .wr_en  (upd_valid),
        .wr_idx (lh_wr),
        .wr_up  (upd_taken)
    );

    always_comb begin
        cho_we = upd_valid && (upd_gbl_pred != upd_loc_pred);
        cho_up = (upd_gbl_pred == upd_taken);
    end

    ctr_table #(.DEPTH(C_DEPTH), .INIT(WEAK_NOT)) u_chooser (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (fetch_pc[SEL_W-1:0]),
        .rd_ctr (c_ctr),
        .wr_en  (cho_we),
        .wr_idx (upd_pc[SEL_W-1:0]),
        .wr_up  (cho_up)
    );

    always_comb begin
        pred_gbl   = ctr_taken(g_ctr);
        pred_loc   = ctr_taken(l_ctr);
        pred_taken = ctr_taken(c_ctr) ? pred_gbl : pred_loc;
    end

    // R6: agreeing components never train the chooser
    a_r6_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_gbl_pred == upd_loc_pred) |-> !cho_we);
    // R5: when both components agree the output follows them
    a_r5_agree_out: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_gbl == pred_loc) |-> pred_taken == pred_gbl);
    // R10: shared record holds without an update
    a_r10_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist));
    // R3: newest outcome enters bit 0 of the shared record
    a_r3_ghist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghist[0] == $past(upd_taken));

endmodule

// File: tb/tb_tourn_pred.sv
module tb_tourn_pred;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic        pred_taken, pred_gbl, pred_loc;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken, upd_gbl_pred, upd_loc_pred;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    tourn_pred dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_taken   (pred_taken),
        .pred_gbl     (pred_gbl),
        .pred_loc     (pred_loc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_gbl_pred (upd_gbl_pred),
        .upd_loc_pred (upd_loc_pred)
    );

    // stimulus vectors: {outcome, pc[3:0]}
    localparam logic [4:0] VEC [24] = '{
        5'b1_0000, 5'b1_0001, 5'b0_0000, 5'b1_0010, 5'b1_0000, 5'b0_0001,
        5'b1_0000, 5'b1_0011, 5'b0_0010, 5'b1_0000, 5'b1_0001, 5'b0_0000,
        5'b1_1111, 5'b1_1111, 5'b0_1111, 5'b1_0000, 5'b0_0011, 5'b1_0001,
        5'b1_0000, 5'b1_0000, 5'b0_1000, 5'b1_1000, 5'b1_0000, 5'b0_0001
    };

    // reference model, written from the requirements
    int gm [256];
    int lm [16];
    int lh [16];
    int ch [16];
    int gh;

    function automatic int sat(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) gm[i] = 1;
        for (int i = 0; i < 16; i++) begin
            lm[i] = 1; lh[i] = 0; ch[i] = 1;
        end
        gh = 0;
    endtask

    task automatic model_pred(input int pc, output bit g, output bit l, output bit p);
        g = (gm[gh] >= 2);
        l = (lm[lh[pc]] >= 2);
        p = (ch[pc] >= 2) ? g : l;
    endtask

    task automatic model_update(input int pc, input bit t, input bit g, input bit l);
        gm[gh]     = sat(gm[gh], t);
        lm[lh[pc]] = sat(lm[lh[pc]], t);
        if (g != l) ch[pc] = sat(ch[pc], g == t);
        lh[pc] = ((lh[pc] << 1) | int'(t)) & 15;
        gh     = ((gh << 1) | int'(t)) & 255;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_pc(input string req, input int pc);
        bit g, l, p;
        @(negedge clk);
        fetch_pc = 32'hA000_0000 | pc;
        #1;
        model_pred(pc, g, l, p);
        chk(req, "pred_gbl", pred_gbl, g);
        chk(req, "pred_loc", pred_loc, l);
        chk(req, "pred_taken", pred_taken, p);
    endtask

    // predict, then train in the same cycle, then observe the trained state
    task automatic step(input string req, input int pc, input bit t);
        bit g, l, p;
        @(negedge clk);
        fetch_pc = 32'h4001_0000 | pc;
        #1;
        model_pred(pc, g, l, p);
        chk(req, "pred_gbl", pred_gbl, g);      // R9
        chk(req, "pred_loc", pred_loc, l);
        chk(req, "pred_taken", pred_taken, p);
        upd_valid    = 1'b1;
        upd_pc       = {$urandom} << 4 | pc;    // R4: upper bits vary
        upd_taken    = t;
        upd_gbl_pred = pred_gbl;
        upd_loc_pred = pred_loc;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(pc, t, g, l);
        model_pred(pc, g, l, p);
        chk("R8", "post-edge pred_taken", pred_taken, p);
        chk("R8", "post-edge pred_gbl", pred_gbl, g);
        chk("R8", "post-edge pred_loc", pred_loc, l);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fetch_pc = '0; upd_valid = 1'b0; upd_pc = '0;
        upd_taken = 1'b0; upd_gbl_pred = 1'b0; upd_loc_pred = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int pc = 0; pc < 16; pc++) check_pc("R1", pc);

        // table walk: R7 both components trained, R3/R4 history indexing
        for (int i = 0; i < 24; i++) step("R7", int'(VEC[i][3:0]), VEC[i][4]);

        // R2: saturate up then down on one branch
        for (int i = 0; i < 7; i++) step("R2", 5, 1'b1);
        for (int i = 0; i < 7; i++) step("R2", 5, 1'b0);

        // R3: period-8 pattern over several branches only the long history captures
        for (int i = 0; i < 64; i++) step("R3", i % 4 + 8, (i % 8) < 3);

        // R6: alternating branches where components disagree
        for (int i = 0; i < 60; i++) step("R6", (i % 2) * 6, (i % 3) != 0);

        // R4: same history record reached through different upper address bits
        for (int i = 0; i < 10; i++) step("R4", 12, i[0]);

        // R10: misleading update data with upd_valid low
        @(negedge clk);
        upd_valid = 1'b0; upd_pc = 32'hFFFF_FFF3; upd_taken = 1'b1;
        upd_gbl_pred = 1'b1; upd_loc_pred = 1'b0;
        repeat (6) @(posedge clk);
        for (int pc = 0; pc < 16; pc++) check_pc("R10", pc);

        // R5: outputs follow chooser across all addresses after training
        for (int i = 0; i < 48; i++) step("R5", (i * 7) % 16, (i % 5) < 2);

        // R1: reset again mid-run
        @(negedge clk) rst_n = 1'b0;
        model_reset();
        @(negedge clk) rst_n = 1'b1;
        for (int pc = 0; pc < 16; pc++) check_pc("R1", pc);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule